// File: doc/BRIEF.md
# Cancellable Miss-Tracking Fill Buffer

This block sits between a level-one data cache and the next memory level and keeps track of cache-line requests that are still in flight. It has ten slots. Each occupied slot holds the line-aligned physical address of a missed line and the micro-op ID of the load that opened it. Up to two loads arrive each cycle. Each load is answered in the same cycle: either accepted, together with the slot that will serve it, or rejected so that the load pipeline retries it later. A load whose line is already being fetched joins the slot that is fetching it and does not open another one.

When memory returns a line it names the slot the line belongs to. The slot is released at the end of that cycle. One cycle later the line data goes out to the pipeline bypass, together with the opening load's ID and the slot index. A merged load recognises its data by that slot index. A pipeline-flush pulse does not release anything. Every occupied slot is marked cancelled, so its data is held back from the pipeline when it arrives, but the slot stays occupied until that fill comes back. A registered counter records how many loads were turned away because no slot was free.

Top module: `fill_slot_buffer`

## Requirements
- R1: After reset `fwd_valid` is 0 and `full_events` is 0, all ten slots are free, and a port that presents no request asserts neither accept nor reject.
- R2: When both ports open new slots in the same cycle, port 0 gets the lowest-index free slot and port 1 gets the next free slot above it. A port 1 request alone gets the lowest free slot.
- R3: A request whose line address (the address with its low `LINE_OFS` bits ignored) matches an occupied, non-cancelled slot is accepted with that slot's index and consumes no free slot. This holds even when every slot is occupied.
- R4: When both ports request the same new line in one cycle, port 0 opens a slot and port 1 is accepted into that same slot.
- R5: A request that finds no matching slot and no free slot is rejected. `full_events` increases by the number of such rejections (0, 1 or 2) one cycle later.
- R6: With exactly one free slot and two requests for different new lines, port 0 is accepted and port 1 is rejected and counted.
- R7: A fill to an occupied, non-cancelled slot produces, on the next cycle, `fwd_valid`=1 with `fwd_uop` equal to the opening load's ID, `fwd_slot` equal to the fill slot and `fwd_data` equal to the fill data.
- R8: A fill releases its slot at the clock edge that ends the fill cycle. A request in the fill cycle does not see that slot as free. A request in the following cycle can open it.
- R9: A flush marks every occupied slot cancelled. A later fill to a cancelled slot releases it but produces no forward. A fill arriving in the same cycle as a flush is not forwarded either.
- R10: Cancelled slots stay occupied until their fill arrives, so requests made after a flush with no fill returned are still rejected as full.
- R11: A request whose line matches only a cancelled slot opens a fresh slot.
- R12: In a cycle with a flush, both ports' requests are rejected and the rejections are not added to `full_events`.
- R13: A fill naming a free slot or an index of `NUM_SLOTS` or above is ignored: nothing is forwarded and no slot changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req0_valid | input | 1 | Port 0 load request present |
| req0_addr | input | PADDR_W | Port 0 physical address |
| req0_uop | input | UOP_W | Port 0 load micro-op ID |
| req0_accept | output | 1 | Port 0 request taken (merged or opened) |
| req0_reject | output | 1 | Port 0 request refused, retry later |
| req0_slot | output | IDX_W | Slot serving port 0 when accepted |
| req1_valid | input | 1 | Port 1 load request present |
| req1_addr | input | PADDR_W | Port 1 physical address |
| req1_uop | input | UOP_W | Port 1 load micro-op ID |
| req1_accept | output | 1 | Port 1 request taken |
| req1_reject | output | 1 | Port 1 request refused |
| req1_slot | output | IDX_W | Slot serving port 1 when accepted |
| flush | input | 1 | Pipeline-flush pulse |
| fill_valid | input | 1 | Memory returns a line |
| fill_slot | input | IDX_W | Slot the returned line belongs to |
| fill_data | input | DATA_W | Returned line data |
| fwd_valid | output | 1 | Forwarded data valid to the pipeline bypass |
| fwd_uop | output | UOP_W | Load ID tagged on the forwarded data |
| fwd_slot | output | IDX_W | Slot index of the forwarded data |
| fwd_data | output | DATA_W | Forwarded line data |
| full_events | output | CNT_W | Count of rejections caused by no free slot |

## Verification
The bench builds the block with its default parameters: ten slots, a 32-bit address with 64-byte lines, 7-bit load IDs, 64-bit data and a 16-bit counter. With ten slots, a few cycles of paired requests fill the buffer completely. That brings the one-free-slot split, merging into a full buffer, and the fill-cycle release boundary into a short vector table. A flush over a full buffer is then followed by a single fill, so that only one slot is free while nine cancelled slots are still occupied. This shows that cancelled slots hold their place, that a line matching a cancelled slot opens a fresh one, and that a cancelled slot forwards nothing.

// File: rtl/fsb_pkg.sv
// Shared types for the fill slot buffer.
package fsb_pkg;

    // Outcome of one request port in one cycle.
    typedef enum logic [1:0] {
        OUT_IDLE   = 2'd0,
        OUT_MERGE  = 2'd1,
        OUT_ALLOC  = 2'd2,
        OUT_REJECT = 2'd3
    } fsb_outcome_e;

endpackage

// File: rtl/fsb_alloc.sv
// Request decision logic, purely combinational.
// Matches both ports against the live (occupied, non-cancelled) slots and
// picks the lowest free slots for new lines. Port 0 has priority. Port 1
// joins port 0's new slot when both carry the same line.
// Assumes the slot state it is given is the registered state of this cycle.
module fsb_alloc
    import fsb_pkg::*;
#(
    parameter int NUM_SLOTS = 10,
    parameter int LINE_W    = 26,
    parameter int IDX_W     = 4
) (
    input  logic [NUM_SLOTS-1:0] slot_valid,
    input  logic [NUM_SLOTS-1:0] slot_cancel,
    input  logic [LINE_W-1:0]    slot_line [NUM_SLOTS],
    input  logic                 req0_valid,
    input  logic [LINE_W-1:0]    req0_line,
    input  logic                 req1_valid,
    input  logic [LINE_W-1:0]    req1_line,
    input  logic                 flush,
    output fsb_outcome_e         out0,
    output fsb_outcome_e         out1,
    output logic [IDX_W-1:0]     idx0,
    output logic [IDX_W-1:0]     idx1,
    output logic [NUM_SLOTS-1:0] alloc0_oh,
    output logic [NUM_SLOTS-1:0] alloc1_oh,
    output logic                 full0,
    output logic                 full1
);

    logic [NUM_SLOTS-1:0] match0, match1;
    logic [IDX_W-1:0]     m0_idx, m1_idx, f0_idx, f1_idx;
    logic                 have_f0, have_f1, take0;

    // Compare both request lines against every live slot.
    always_comb begin : match_scan
        match0 = '0;
        match1 = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            match0[i] = slot_valid[i] && !slot_cancel[i] && (slot_line[i] == req0_line);
            match1[i] = slot_valid[i] && !slot_cancel[i] && (slot_line[i] == req1_line);
        end
    end

    // Encode the matching slots and the lowest two free slots.
    always_comb begin : index_scan
        m0_idx  = '0;
        m1_idx  = '0;
        f0_idx  = '0;
        f1_idx  = '0;
        have_f0 = 1'b0;
        have_f1 = 1'b0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (match0[i]) m0_idx = IDX_W'(i);
            if (match1[i]) m1_idx = IDX_W'(i);
            if (!slot_valid[i]) begin
                have_f0 = 1'b1;
                f0_idx  = IDX_W'(i);
            end
        end
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!slot_valid[i] && (IDX_W'(i) != f0_idx)) begin
                have_f1 = 1'b1;
                f1_idx  = IDX_W'(i);
            end
        end
    end

    // Decide port 0 first, then port 1 given port 0's choice.
    always_comb begin : decide
        out0 = OUT_IDLE;
        idx0 = '0;
        if (req0_valid) begin
            if (flush) begin
                out0 = OUT_REJECT;
            end else if (|match0) begin
                out0 = OUT_MERGE;
                idx0 = m0_idx;
            end else if (have_f0) begin
                out0 = OUT_ALLOC;
                idx0 = f0_idx;
            end else begin
                out0 = OUT_REJECT;
            end
        end
        take0 = (out0 == OUT_ALLOC);
        out1  = OUT_IDLE;
        idx1  = '0;
        if (req1_valid) begin
            if (flush) begin
                out1 = OUT_REJECT;
            end else if (|match1) begin
                out1 = OUT_MERGE;
                idx1 = m1_idx;
            end else if (take0 && (req1_line == req0_line)) begin
                out1 = OUT_MERGE;
                idx1 = idx0;
            end else if (take0 ? have_f1 : have_f0) begin
                out1 = OUT_ALLOC;
                idx1 = take0 ? f1_idx : f0_idx;
            end else begin
                out1 = OUT_REJECT;
            end
        end
    end

    // One-hot allocation strobes and full-rejection flags.
    always_comb begin : strobes
        alloc0_oh = (out0 == OUT_ALLOC) ? (NUM_SLOTS'(1) << idx0) : '0;
        alloc1_oh = (out1 == OUT_ALLOC) ? (NUM_SLOTS'(1) << idx1) : '0;
        full0     = (out0 == OUT_REJECT) && !flush;
        full1     = (out1 == OUT_REJECT) && !flush;
    end

endmodule

// File: rtl/fsb_slot_array.sv
// Slot storage: occupied and cancelled flags, line address and opening load ID.
// A fill to an occupied slot releases it. A flush marks every occupied slot
// cancelled. Assumes allocation strobes only name free slots and never
// coincide with a flush.
module fsb_slot_array #(
    parameter int NUM_SLOTS = 10,
    parameter int LINE_W    = 26,
    parameter int UOP_W     = 7,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] alloc0_oh,
    input  logic [NUM_SLOTS-1:0] alloc1_oh,
    input  logic [LINE_W-1:0]    line0,
    input  logic [LINE_W-1:0]    line1,
    input  logic [UOP_W-1:0]     uop0,
    input  logic [UOP_W-1:0]     uop1,
    input  logic                 flush,
    input  logic                 fill_valid,
    input  logic [IDX_W-1:0]     fill_slot,
    output logic [NUM_SLOTS-1:0] slot_valid,
    output logic [NUM_SLOTS-1:0] slot_cancel,
    output logic [LINE_W-1:0]    slot_line [NUM_SLOTS],
    output logic                 fill_hit,
    output logic                 fill_cancelled,
    output logic [UOP_W-1:0]     fill_uop
);

    logic [UOP_W-1:0]     slot_uop [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] fill_free;

    // Select the occupied slot a fill names, with its cancel flag and load ID.
    always_comb begin : fill_select
        fill_uop = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            fill_free[i] = fill_valid && (fill_slot == IDX_W'(i)) && slot_valid[i];
            if (fill_free[i]) fill_uop = slot_uop[i];
        end
        fill_hit       = |fill_free;
        fill_cancelled = |(fill_free & slot_cancel);
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // Occupancy and cancel state: release on fill, open on allocation, cancel on flush.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_valid[g]  <= 1'b0;
                slot_cancel[g] <= 1'b0;
            end else if (fill_free[g]) begin
                slot_valid[g]  <= 1'b0;
                slot_cancel[g] <= 1'b0;
            end else if (alloc0_oh[g] || alloc1_oh[g]) begin
                slot_valid[g]  <= 1'b1;
                slot_cancel[g] <= 1'b0;
            end else if (flush && slot_valid[g]) begin
                slot_cancel[g] <= 1'b1;
            end
        end

        // Payload: line address and load ID captured when the slot opens.
        always_ff @(posedge clk) begin
            if (alloc0_oh[g]) begin
                slot_line[g] <= line0;
                slot_uop[g]  <= uop0;
            end else if (alloc1_oh[g]) begin
                slot_line[g] <= line1;
                slot_uop[g]  <= uop1;
            end
        end
    end

endmodule

// File: rtl/fsb_forward.sv
// Forward stage: registers fill data, load ID and slot toward the pipeline
// bypass, one cycle after the fill. Data of cancelled slots, or of a fill in a
// flush cycle, is withheld.
module fsb_forward #(
    parameter int UOP_W  = 7,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_hit,
    input  logic              fill_cancelled,
    input  logic              flush,
    input  logic [UOP_W-1:0]  fill_uop,
    input  logic [IDX_W-1:0]  fill_slot,
    input  logic [DATA_W-1:0] fill_data,
    output logic              fwd_valid,
    output logic [UOP_W-1:0]  fwd_uop,
    output logic [IDX_W-1:0]  fwd_slot,
    output logic [DATA_W-1:0] fwd_data
);

    // Valid strobe for forwarded data.
    always_ff @(posedge clk) begin
        if (!rst_n) fwd_valid <= 1'b0;
        else        fwd_valid <= fill_hit && !fill_cancelled && !flush;
    end

    // Capture the payload on every accepted fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_uop  <= '0;
            fwd_slot <= '0;
            fwd_data <= '0;
        end else if (fill_hit) begin
            fwd_uop  <= fill_uop;
            fwd_slot <= fill_slot;
            fwd_data <= fill_data;
        end
    end

endmodule

// File: rtl/fsb_full_counter.sv
// Counts rejections caused by the absence of a free slot, 0 to 2 per cycle.
// The count wraps at its width.
module fsb_full_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full0,
    input  logic             full1,
    output logic [CNT_W-1:0] count
);

    // Add this cycle's full rejections.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + CNT_W'(full0) + CNT_W'(full1);
    end

endmodule

// File: rtl/fill_slot_buffer.sv
// Top of the cancellable miss-tracking fill buffer.
// Two load ports are answered in the same cycle. Fills name their slot, and
// forwarded data leaves one cycle after the fill. A flush cancels slots but
// does not free them.
// Assumes memory only returns fills for slots it was given.
module fill_slot_buffer
    import fsb_pkg::*;
#(
    parameter int  NUM_SLOTS = 10,
    parameter int  PADDR_W   = 32,
    parameter int  LINE_OFS  = 6,
    parameter int  UOP_W     = 7,
    parameter int  DATA_W    = 64,
    parameter int  CNT_W     = 16,
    localparam int IDX_W     = $clog2(NUM_SLOTS),
    localparam int LINE_W    = PADDR_W - LINE_OFS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req0_valid,
    input  logic [PADDR_W-1:0] req0_addr,
    input  logic [UOP_W-1:0]   req0_uop,
    output logic               req0_accept,
    output logic               req0_reject,
    output logic [IDX_W-1:0]   req0_slot,
    input  logic               req1_valid,
    input  logic [PADDR_W-1:0] req1_addr,
    input  logic [UOP_W-1:0]   req1_uop,
    output logic               req1_accept,
    output logic               req1_reject,
    output logic [IDX_W-1:0]   req1_slot,
    input  logic               flush,
    input  logic               fill_valid,
    input  logic [IDX_W-1:0]   fill_slot,
    input  logic [DATA_W-1:0]  fill_data,
    output logic               fwd_valid,
    output logic [UOP_W-1:0]   fwd_uop,
    output logic [IDX_W-1:0]   fwd_slot,
    output logic [DATA_W-1:0]  fwd_data,
    output logic [CNT_W-1:0]   full_events
);

    logic [NUM_SLOTS-1:0] slot_valid, slot_cancel, alloc0_oh, alloc1_oh;
    logic [LINE_W-1:0]    slot_line [NUM_SLOTS];
    logic [LINE_W-1:0]    line0, line1;
    fsb_outcome_e         out0, out1;
    logic                 full0, full1;
    logic                 fill_hit, fill_cancelled;
    logic [UOP_W-1:0]     fill_uop;

    // Strip the offset within the line from both request addresses.
    always_comb begin : line_strip
        line0 = req0_addr[PADDR_W-1:LINE_OFS];
        line1 = req1_addr[PADDR_W-1:LINE_OFS];
    end

    // Turn port outcomes into accept and reject pins.
    always_comb begin : port_pins
        req0_accept = (out0 == OUT_MERGE) || (out0 == OUT_ALLOC);
        req1_accept = (out1 == OUT_MERGE) || (out1 == OUT_ALLOC);
        req0_reject = (out0 == OUT_REJECT);
        req1_reject = (out1 == OUT_REJECT);
    end

    fsb_alloc #(.NUM_SLOTS(NUM_SLOTS), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_alloc (
        .slot_valid (slot_valid),
        .slot_cancel(slot_cancel),
        .slot_line  (slot_line),
        .req0_valid (req0_valid),
        .req0_line  (line0),
        .req1_valid (req1_valid),
        .req1_line  (line1),
        .flush      (flush),
        .out0       (out0),
        .out1       (out1),
        .idx0       (req0_slot),
        .idx1       (req1_slot),
        .alloc0_oh  (alloc0_oh),
        .alloc1_oh  (alloc1_oh),
        .full0      (full0),
        .full1      (full1)
    );

    fsb_slot_array #(.NUM_SLOTS(NUM_SLOTS), .LINE_W(LINE_W), .UOP_W(UOP_W), .IDX_W(IDX_W)) u_slots (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc0_oh     (alloc0_oh),
        .alloc1_oh     (alloc1_oh),
        .line0         (line0),
        .line1         (line1),
        .uop0          (req0_uop),
        .uop1          (req1_uop),
        .flush         (flush),
        .fill_valid    (fill_valid),
        .fill_slot     (fill_slot),
        .slot_valid    (slot_valid),
        .slot_cancel   (slot_cancel),
        .slot_line     (slot_line),
        .fill_hit      (fill_hit),
        .fill_cancelled(fill_cancelled),
        .fill_uop      (fill_uop)
    );

    fsb_forward #(.UOP_W(UOP_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fwd (
        .clk           (clk),
        .rst_n         (rst_n),
        .fill_hit      (fill_hit),
        .fill_cancelled(fill_cancelled),
        .flush         (flush),
        .fill_uop      (fill_uop),
        .fill_slot     (fill_slot),
        .fill_data     (fill_data),
        .fwd_valid     (fwd_valid),
        .fwd_uop       (fwd_uop),
        .fwd_slot      (fwd_slot),
        .fwd_data      (fwd_data)
    );

    fsb_full_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .full0(full0),
        .full1(full1),
        .count(full_events)
    );

endmodule

// File: rtl/fsb_checker.sv
// Port-level properties of the fill slot buffer, bound to the top module.
module fsb_checker #(
    parameter int PADDR_W  = 32,
    parameter int LINE_OFS = 6,
    parameter int IDX_W    = 4,
    parameter int CNT_W    = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req0_valid,
    input logic [PADDR_W-1:0] req0_addr,
    input logic               req0_accept,
    input logic               req0_reject,
    input logic [IDX_W-1:0]   req0_slot,
    input logic               req1_valid,
    input logic [PADDR_W-1:0] req1_addr,
    input logic               req1_accept,
    input logic               req1_reject,
    input logic [IDX_W-1:0]   req1_slot,
    input logic               flush,
    input logic               fill_valid,
    input logic               fwd_valid,
    input logic [CNT_W-1:0]   full_events
);

    logic same_line;
    assign same_line = (req0_addr[PADDR_W-1:LINE_OFS] == req1_addr[PADDR_W-1:LINE_OFS]);

    assert_idle_port0_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req0_valid |-> (!req0_accept && !req0_reject));
    assert_idle_port1_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req1_valid |-> (!req1_accept && !req1_reject));
    assert_distinct_slots_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req0_accept && req1_accept && !same_line) |-> (req0_slot != req1_slot));
    assert_shared_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req0_accept && req1_accept && same_line) |-> (req0_slot == req1_slot));
    assert_flush_rejects_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && (req0_valid || req1_valid)) |-> (!req0_accept && !req1_accept));
    assert_flush_blocks_fwd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !fwd_valid);
    assert_fwd_needs_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(fill_valid));
    assert_count_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush || (!req0_reject && !req1_reject)) |=> $stable(full_events));

endmodule

bind fill_slot_buffer fsb_checker #(
    .PADDR_W(PADDR_W), .LINE_OFS(LINE_OFS), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_fsb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req0_valid (req0_valid),
    .req0_addr  (req0_addr),
    .req0_accept(req0_accept),
    .req0_reject(req0_reject),
    .req0_slot  (req0_slot),
    .req1_valid (req1_valid),
    .req1_addr  (req1_addr),
    .req1_accept(req1_accept),
    .req1_reject(req1_reject),
    .req1_slot  (req1_slot),
    .flush      (flush),
    .fill_valid (fill_valid),
    .fwd_valid  (fwd_valid),
    .full_events(full_events)
);

// File: tb/test_fill_slot_buffer.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked cycle by cycle, then directed tests.
module test_fill_slot_buffer;

    localparam int IDX_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req0_valid = 0, req1_valid = 0, flush = 0, fill_valid = 0;
    logic [31:0] req0_addr = '0, req1_addr = '0;
    logic [6:0]  req0_uop = '0, req1_uop = '0;
    logic [3:0]  fill_slot = '0;
    logic [63:0] fill_data = '0;
    logic        req0_accept, req0_reject, req1_accept, req1_reject, fwd_valid;
    logic [3:0]  req0_slot, req1_slot, fwd_slot;
    logic [6:0]  fwd_uop;
    logic [63:0] fwd_data;
    logic [15:0] full_events;

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fill_slot_buffer i_fill_slot_buffer (
        .clk(clk), .rst_n(rst_n),
        .req0_valid(req0_valid), .req0_addr(req0_addr), .req0_uop(req0_uop),
        .req0_accept(req0_accept), .req0_reject(req0_reject), .req0_slot(req0_slot),
        .req1_valid(req1_valid), .req1_addr(req1_addr), .req1_uop(req1_uop),
        .req1_accept(req1_accept), .req1_reject(req1_reject), .req1_slot(req1_slot),
        .flush(flush), .fill_valid(fill_valid), .fill_slot(fill_slot), .fill_data(fill_data),
        .fwd_valid(fwd_valid), .fwd_uop(fwd_uop), .fwd_slot(fwd_slot), .fwd_data(fwd_data),
        .full_events(full_events)
    );

    typedef struct packed {
        logic       r0v; logic [7:0] r0l; logic [6:0] r0u;
        logic       r1v; logic [7:0] r1l; logic [6:0] r1u;
        logic       fl;  logic fv; logic [3:0] fs;
        logic       a0;  logic [3:0] s0;
        logic       a1;  logic [3:0] s1;
        logic       fw;  logic [6:0] fu;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1,8'h10,7'd1,  1'b1,8'h11,7'd2,  1'b0,1'b0,4'd0,  1'b1,4'd0, 1'b1,4'd1, 1'b0,7'd0},
        '{1'b1,8'h10,7'd3,  1'b1,8'h12,7'd4,  1'b0,1'b0,4'd0,  1'b1,4'd0, 1'b1,4'd2, 1'b0,7'd0},
        '{1'b1,8'h13,7'd5,  1'b1,8'h13,7'd6,  1'b0,1'b0,4'd0,  1'b1,4'd3, 1'b1,4'd3, 1'b0,7'd0},
        '{1'b1,8'h14,7'd7,  1'b1,8'h15,7'd8,  1'b0,1'b0,4'd0,  1'b1,4'd4, 1'b1,4'd5, 1'b0,7'd0},
        '{1'b1,8'h16,7'd9,  1'b1,8'h17,7'd10, 1'b0,1'b0,4'd0,  1'b1,4'd6, 1'b1,4'd7, 1'b0,7'd0},
        '{1'b1,8'h18,7'd11, 1'b0,8'h00,7'd0,  1'b0,1'b0,4'd0,  1'b1,4'd8, 1'b0,4'd0, 1'b0,7'd0},
        '{1'b1,8'h19,7'd12, 1'b1,8'h1A,7'd13, 1'b0,1'b0,4'd0,  1'b1,4'd9, 1'b0,4'd0, 1'b0,7'd0},
        '{1'b1,8'h1B,7'd14, 1'b1,8'h1C,7'd15, 1'b0,1'b0,4'd0,  1'b0,4'd0, 1'b0,4'd0, 1'b0,7'd0},
        '{1'b1,8'h10,7'd16, 1'b1,8'h1B,7'd17, 1'b0,1'b0,4'd0,  1'b1,4'd0, 1'b0,4'd0, 1'b0,7'd0},
        '{1'b1,8'h1D,7'd18, 1'b0,8'h00,7'd0,  1'b0,1'b1,4'd2,  1'b0,4'd0, 1'b0,4'd0, 1'b1,7'd4},
        '{1'b1,8'h1D,7'd18, 1'b0,8'h00,7'd0,  1'b0,1'b0,4'd0,  1'b1,4'd2, 1'b0,4'd0, 1'b0,7'd0},
        '{1'b0,8'h00,7'd0,  1'b0,8'h00,7'd0,  1'b0,1'b1,4'd12, 1'b0,4'd0, 1'b0,4'd0, 1'b0,7'd0},
        '{1'b1,8'h1E,7'd19, 1'b1,8'h1F,7'd20, 1'b1,1'b0,4'd0,  1'b0,4'd0, 1'b0,4'd0, 1'b0,7'd0},
        '{1'b0,8'h00,7'd0,  1'b0,8'h00,7'd0,  1'b0,1'b1,4'd0,  1'b0,4'd0, 1'b0,4'd0, 1'b0,7'd0},
        '{1'b1,8'h11,7'd21, 1'b1,8'h1E,7'd22, 1'b0,1'b0,4'd0,  1'b1,4'd0, 1'b0,4'd0, 1'b0,7'd0},
        '{1'b0,8'h00,7'd0,  1'b0,8'h00,7'd0,  1'b0,1'b1,4'd0,  1'b0,4'd0, 1'b0,4'd0, 1'b1,7'd21},
        '{1'b0,8'h00,7'd0,  1'b0,8'h00,7'd0,  1'b0,1'b1,4'd0,  1'b0,4'd0, 1'b0,4'd0, 1'b0,7'd0},
        '{1'b1,8'h20,7'd23, 1'b1,8'h21,7'd24, 1'b0,1'b0,4'd0,  1'b1,4'd0, 1'b0,4'd0, 1'b0,7'd0}
    };

    function automatic string tag_of(int k);
        case (k)
            0:       return "R1";
            1, 8:    return "R3";
            2:       return "R4";
            6, 17:   return "R6";
            7:       return "R5";
            9, 10:   return "R8";
            11, 16:  return "R13";
            12:      return "R12";
            13:      return "R9";
            14:      return "R10,R11";
            15:      return "R7";
            default: return "R2";
        endcase
    endfunction

    function automatic logic [63:0] data_for(logic [3:0] s);
        return {8{s, 4'h5}};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req0_valid = 0; req1_valid = 0; flush = 0; fill_valid = 0;
    endtask

    task automatic put_req(input bit p, input logic [7:0] line, input logic [6:0] uop);
        if (!p) begin
            req0_valid = 1; req0_addr = {18'd0, line, uop[5:0]}; req0_uop = uop;
        end else begin
            req1_valid = 1; req1_addr = {18'd0, line, uop[5:0]}; req1_uop = uop;
        end
    endtask

    task automatic put_fill(input logic [3:0] s);
        fill_valid = 1; fill_slot = s; fill_data = data_for(s);
    endtask

    initial begin : main
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1", "fwd_valid after reset", fwd_valid, 0);
        chk("R1", "full_events after reset", full_events, 0);
        chk("R1", "idle accept", req0_accept | req1_accept, 0);
        chk("R1", "idle reject", req0_reject | req1_reject, 0);
        @(negedge clk);

        // Vector table walk, one cycle per vector.
        for (int k = 0; k < NV; k++) begin
            vec_t v;
            string t;
            v = VECS[k];
            t = tag_of(k);
            idle_inputs();
            if (v.r0v) put_req(0, v.r0l, v.r0u);
            if (v.r1v) put_req(1, v.r1l, v.r1u);
            flush = v.fl;
            if (v.fv) put_fill(v.fs);
            #1;
            if (v.r0v) begin
                chk(t, "port0 accept", req0_accept, v.a0);
                chk(t, "port0 reject", req0_reject, !v.a0);
                if (v.a0) chk(t, "port0 slot", req0_slot, v.s0);
                if (!v.a0 && !v.fl) exp_cnt++;
            end
            if (v.r1v) begin
                chk(t, "port1 accept", req1_accept, v.a1);
                chk(t, "port1 reject", req1_reject, !v.a1);
                if (v.a1) chk(t, "port1 slot", req1_slot, v.s1);
                if (!v.a1 && !v.fl) exp_cnt++;
            end
            @(negedge clk);
            chk(t, "fwd_valid", fwd_valid, v.fw);
            if (v.fw) begin
                chk("R7", "fwd_uop", fwd_uop, v.fu);
                chk("R7", "fwd_slot", fwd_slot, v.fs);
                chk("R7", "fwd_data", fwd_data, data_for(v.fs));
            end
            chk("R5", "full_events", full_events, exp_cnt);
        end

        // Directed: reset clears state, fill into free slot ignored.
        idle_inputs();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1", "full_events after second reset", full_events, 0);
        chk("R1", "fwd_valid after second reset", fwd_valid, 0);
        put_fill(4'd5);
        @(negedge clk);
        chk("R13", "fill to free slot forwards nothing", fwd_valid, 0);
        idle_inputs();
        put_req(0, 8'h30, 7'd40);
        put_req(1, 8'h31, 7'd41);
        #1;
        chk("R1", "empty buffer port0 slot", req0_slot, 0);
        chk("R2", "empty buffer port1 slot", req1_slot, 1);
        chk("R2", "both accepted", req0_accept & req1_accept, 1);
        @(negedge clk);
        // Flush and fill of a live slot in the same cycle: withheld.
        idle_inputs();
        flush = 1;
        put_fill(4'd0);
        @(negedge clk);
        chk("R9", "fill in flush cycle withheld", fwd_valid, 0);
        idle_inputs();
        // Slot 0 freed, slot 1 cancelled: line 31 opens fresh at slot 0.
        put_req(1, 8'h31, 7'd42);
        #1;
        chk("R11", "cancelled line opens fresh slot", req1_slot, 0);
        chk("R2", "port1 alone takes lowest free", req1_accept, 1);
        @(negedge clk);
        idle_inputs();
        @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : watchdog
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule